// File: doc/BRIEF.md
# Storage Key Reference/Change Updater

Each page of absolute memory has a small storage key. This block keeps the keys in a key RAM indexed by page number. Each time a new translation of an absolute address is installed in the translation cache, the block reads the page's key, modifies it and writes it back as a single sequence. The update records that the page was referenced and, for stores, that it was changed.

The block also returns a write-permission flag for the cache entry. A load or an instruction fetch on a page whose change bit is still clear returns with write permission removed. A later store therefore misses in the cache, comes back through this block and sets the change bit. Addresses at or above a memory-size limit bypass the key RAM and leave the permission untouched.

A host port lets software read and write keys directly. The host port always wins the RAM over the updater. The updater accepts no new request until the write-back of its current key has completed.

Top module: `skey_rc_updater`

## Requirements
- R1: After reset `req_ready` is 1, `done` is 0 and every key reads back as 0 through the host port.
- R2: A request with `req_addr >= mem_limit` leaves the key RAM untouched. One edge after acceptance it pulses `done` with `wr_ok_out` equal to the request's `req_wr_ok`.
- R3: The key index is the page number `req_addr >> 12`, taken modulo the RAM depth (64 by default). The byte offset within the 4 KiB page has no effect.
- R4: Access code 2'b00 is a load, 2'b10 is a fetch and 2'b11 is treated as a load. For these, `wr_ok_out` is 0 when the key's change bit (bit 0) was clear before the update. Otherwise it is `req_wr_ok`.
- R5: A store (code 2'b01) sets the change bit (bit 0) of the key and returns `wr_ok_out = req_wr_ok`.
- R6: Every updating access sets the reference bit (bit 1). Key bits 6..2 (access key and fetch-protect) keep their value.
- R7: An in-range request is accepted on an edge with `req_valid` and `req_ready` both high. `req_ready` then stays low until `done`. With no host traffic, the key is read on the next edge and written back on the edge after that. `done` pulses high for one cycle after the write-back.
- R8: The host port writes when `host_en` and `host_we` are both high. It reads when `host_en` is high and `host_we` is low, with the data on `host_rkey` after the next edge. The host port has priority: each cycle with `host_en` high delays the updater by one cycle.
- R9: The host may write the page being updated after the updater has read its key but before the write-back. In that case the updater reads the key again, so the final key is the host's value with R5/R6 applied, and `wr_ok_out` follows from the host's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation update request |
| req_addr | input | ADDR_W | Absolute address |
| req_acc | input | 2 | Access type code |
| req_wr_ok | input | 1 | Incoming write permission |
| mem_limit | input | ADDR_W | Memory size; addresses at or above it are skipped |
| req_ready | output | 1 | Updater idle, request can be accepted |
| done | output | 1 | One-cycle completion pulse |
| wr_ok_out | output | 1 | Final write permission, valid with `done` |
| host_en | input | 1 | Host key RAM access |
| host_we | input | 1 | Host write (else read) |
| host_idx | input | IDX_W | Host key index |
| host_wkey | input | 7 | Host write data |
| host_rkey | output | 7 | Host read data, one edge after the read |

## Verification
A skipped request has `done` due on the first edge after acceptance. An updating request has it due on the third edge after acceptance, plus one edge per cycle of host traffic and two more when a host write forces a reread. The bench drives on falling edges and polls `done` on each falling edge after acceptance. It compares the count of elapsed edges with the expected latency and then checks `wr_ok_out` in that same sample. Key contents are read back through the host port one edge after the read is issued, and compared with a bench-side key model.

// File: rtl/skey_pkg.sv
package skey_pkg;
  localparam int KEY_W   = 7;
  localparam int BIT_CHG = 0;
  localparam int BIT_REF = 1;

  typedef logic [KEY_W-1:0] key_t;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    S_IDLE   = 2'b00,
    S_LOOKUP = 2'b01,
    S_COMMIT = 2'b10
  } upd_state_e;

  // New key value after an access of the given type.
  function automatic key_t key_after(key_t k, acc_e a);
    key_t n;
    n = k;
    n[BIT_REF] = 1'b1;
    if (a == ACC_STORE) n[BIT_CHG] = 1'b1;
    return n;
  endfunction

  // Write permission handed back to the translation cache.
  function automatic logic perm_after(key_t k, acc_e a, logic wr_in);
    if (a == ACC_STORE) return wr_in;
    return wr_in & k[BIT_CHG];
  endfunction
endpackage

// File: rtl/skey_page_map.sv
module skey_page_map #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int IDX_W      = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] limit,
  output logic [IDX_W-1:0]  idx,
  output logic              in_range
);
  assign idx      = addr[PAGE_SHIFT+IDX_W-1:PAGE_SHIFT];
  assign in_range = (addr < limit);
endmodule

// File: rtl/skey_ram.sv
module skey_ram #(
  parameter int DEPTH = 64,
  parameter int KEY_W = 7,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [KEY_W-1:0] wdata,
  output logic [KEY_W-1:0] rdata
);
  logic [KEY_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata <= '0;
    end else if (en) begin
      if (we) mem[idx] <= wdata;
      else    rdata    <= mem[idx];
    end
  end
endmodule

// File: rtl/skey_rmw_ctrl.sv
module skey_rmw_ctrl
  import skey_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_acc,
  input  logic             req_wr_ok,
  input  logic [IDX_W-1:0] req_idx,
  input  logic             req_in_range,
  input  logic             host_en,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_idx,
  input  key_t             ram_rdata,
  output logic             ready,
  output logic             done,
  output logic             wr_ok_out,
  output logic             upd_en,
  output logic             upd_we,
  output logic [IDX_W-1:0] upd_idx,
  output key_t             upd_wkey
);
  upd_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  acc_e             acc_q;
  logic             wr_q;
  key_t             key_q;
  logic             fresh_q;

  // Named internal events
  logic accept, skip_fire, lookup_fire, commit_fire, host_hit;
  key_t cur_key;

  assign ready       = (state_q == S_IDLE);
  assign accept      = ready & req_valid;
  assign skip_fire   = accept & ~req_in_range;
  assign lookup_fire = (state_q == S_LOOKUP) & ~host_en;
  assign host_hit    = host_en & host_we & (host_idx == idx_q);
  assign commit_fire = (state_q == S_COMMIT) & ~host_en;
  assign cur_key     = fresh_q ? ram_rdata : key_q;

  assign upd_en   = lookup_fire | commit_fire;
  assign upd_we   = commit_fire;
  assign upd_idx  = idx_q;
  assign upd_wkey = key_after(cur_key, acc_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      idx_q     <= '0;
      acc_q     <= ACC_LOAD;
      wr_q      <= 1'b0;
      key_q     <= '0;
      fresh_q   <= 1'b0;
      done      <= 1'b0;
      wr_ok_out <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (accept) begin
            if (req_in_range) begin
              state_q <= S_LOOKUP;
              idx_q   <= req_idx;
              acc_q   <= acc_e'(req_acc);
              wr_q    <= req_wr_ok;
            end else begin
              done      <= 1'b1;
              wr_ok_out <= req_wr_ok;
            end
          end
        end
        S_LOOKUP: begin
          if (lookup_fire) begin
            state_q <= S_COMMIT;
            fresh_q <= 1'b1;
          end
        end
        S_COMMIT: begin
          fresh_q <= 1'b0;
          if (host_hit) begin
            state_q <= S_LOOKUP;
          end else if (commit_fire) begin
            state_q   <= S_IDLE;
            done      <= 1'b1;
            wr_ok_out <= perm_after(cur_key, acc_q, wr_q);
          end else begin
            key_q <= cur_key;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R2: skipped request completes next edge with untouched permission
  p_skip_perm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    skip_fire |=> (done && wr_ok_out == $past(req_wr_ok)));

  // R4: load/fetch on an unchanged page drops write permission
  p_load_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_fire && acc_q != ACC_STORE && !cur_key[BIT_CHG]) |=> (done && !wr_ok_out));

  // R8: host traffic holds the updater in lookup
  p_host_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_LOOKUP && host_en) |=> (state_q == S_LOOKUP));

  // R9: a host write to the in-flight page forces a reread
  p_reread_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_COMMIT && host_hit) |=> (state_q == S_LOOKUP && !done));
endmodule

// File: rtl/skey_rc_updater.sv
module skey_rc_updater
  import skey_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int DEPTH      = 64,
  localparam int IDX_W     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_acc,
  input  logic              req_wr_ok,
  input  logic [ADDR_W-1:0] mem_limit,
  output logic              req_ready,
  output logic              done,
  output logic              wr_ok_out,
  input  logic              host_en,
  input  logic              host_we,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [KEY_W-1:0]  host_wkey,
  output logic [KEY_W-1:0]  host_rkey
);
  logic [IDX_W-1:0] map_idx;
  logic             map_in_range;
  logic             upd_en, upd_we;
  logic [IDX_W-1:0] upd_idx;
  key_t             upd_wkey;
  logic             ram_en, ram_we;
  logic [IDX_W-1:0] ram_idx;
  key_t             ram_wdata, ram_rdata;

  skey_page_map #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .IDX_W(IDX_W)) u_map (
    .addr(req_addr), .limit(mem_limit), .idx(map_idx), .in_range(map_in_range)
  );

  skey_rmw_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_acc(req_acc), .req_wr_ok(req_wr_ok),
    .req_idx(map_idx), .req_in_range(map_in_range),
    .host_en(host_en), .host_we(host_we), .host_idx(host_idx),
    .ram_rdata(ram_rdata),
    .ready(req_ready), .done(done), .wr_ok_out(wr_ok_out),
    .upd_en(upd_en), .upd_we(upd_we), .upd_idx(upd_idx), .upd_wkey(upd_wkey)
  );

  // Host port owns the RAM whenever it is active.
  assign ram_en    = host_en | upd_en;
  assign ram_we    = host_en ? host_we   : upd_we;
  assign ram_idx   = host_en ? host_idx  : upd_idx;
  assign ram_wdata = host_en ? host_wkey : upd_wkey;

  skey_ram #(.DEPTH(DEPTH), .KEY_W(KEY_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .en(ram_en), .we(ram_we), .idx(ram_idx),
    .wdata(ram_wdata), .rdata(ram_rdata)
  );

  assign host_rkey = ram_rdata;

  // R8: updater never drives the RAM while the host uses it
  p_host_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_en |-> !upd_en);

  // R6: every updater write-back carries the reference bit
  p_ref_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_we |-> upd_wkey[BIT_REF]);

  // R7: the updater returns to ready only together with done
  p_ready_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> done);
endmodule

// File: tb/skey_rc_updater_tb.sv
`timescale 1ns/1ps
module skey_rc_updater_tb;
  localparam int ADDR_W = 32;
  localparam int DEPTH  = 64;
  localparam int IDX_W  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0] req_acc = '0;
  logic req_wr_ok = 1'b0;
  logic [ADDR_W-1:0] mem_limit = 32'h40000;
  logic req_ready, done, wr_ok_out;
  logic host_en = 1'b0, host_we = 1'b0;
  logic [IDX_W-1:0] host_idx = '0;
  logic [6:0] host_wkey = '0;
  logic [6:0] host_rkey;

  int n_chk = 0, n_fail = 0;
  logic [6:0] mk [DEPTH];

  always #2.5 clk = ~clk;

  skey_rc_updater u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_acc(req_acc), .req_wr_ok(req_wr_ok), .mem_limit(mem_limit),
    .req_ready(req_ready), .done(done), .wr_ok_out(wr_ok_out),
    .host_en(host_en), .host_we(host_we), .host_idx(host_idx),
    .host_wkey(host_wkey), .host_rkey(host_rkey)
  );

  function automatic logic [6:0] exp_key(logic [6:0] k, logic [1:0] a);
    logic [6:0] r;
    r = k | 7'b0000010;
    if (a == 2'b01) r = r | 7'b0000001;
    return r;
  endfunction

  function automatic logic exp_perm(logic [6:0] k, logic [1:0] a, logic w);
    if (a == 2'b01) return w;
    return w && k[0];
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(int idx, logic [6:0] v);
    @(negedge clk);
    host_en = 1; host_we = 1; host_idx = idx[IDX_W-1:0]; host_wkey = v;
    @(negedge clk);
    host_en = 0; host_we = 0;
    mk[idx] = v;
  endtask

  task automatic host_check(int idx, string req);
    @(negedge clk);
    host_en = 1; host_we = 0; host_idx = idx[IDX_W-1:0];
    @(negedge clk);
    host_en = 0;
    check(host_rkey == mk[idx], req, host_rkey, mk[idx]);
  endtask

  // Issue one request; hstall cycles of host reads, optional host write
  // of hval to the same page between lookup and write-back.
  task automatic do_req(logic [31:0] addr, logic [1:0] acc, logic w,
                        int hstall, bit hwr, logic [6:0] hval, string req);
    int idx, lat, exp_lat;
    bit skip, wrote;
    logic [6:0] base;
    logic exp_w;
    idx  = int'(addr[17:12]);
    skip = (addr >= mem_limit);
    wrote = 0;
    @(negedge clk);
    check(req_ready == 1'b1, "R7", req_ready, 1);
    req_valid = 1; req_addr = addr; req_acc = acc; req_wr_ok = w;
    lat = 0;
    forever begin
      @(negedge clk);
      req_valid = 0;
      host_en = 0; host_we = 0;
      lat++;
      if (done || lat > 30) break;
      if (lat == 1) check(req_ready == 1'b0, "R7", req_ready, 0);
      if (lat <= hstall) begin
        host_en = 1; host_we = 0; host_idx = '0;
      end else if (hwr && !wrote && lat == hstall + 2) begin
        host_en = 1; host_we = 1; host_idx = idx[IDX_W-1:0]; host_wkey = hval;
        wrote = 1;
      end
    end
    host_en = 0; host_we = 0;
    if (skip) begin
      exp_lat = 1;
      exp_w = w;
    end else begin
      if (wrote) mk[idx] = hval;
      base = mk[idx];
      exp_w = exp_perm(base, acc, w);
      mk[idx] = exp_key(base, acc);
      exp_lat = 3 + hstall + (wrote ? 2 : 0);
    end
    check(lat == exp_lat, {req, " latency"}, lat, exp_lat);
    check(wr_ok_out == exp_w, {req, " wr_ok"}, wr_ok_out, exp_w);
    @(negedge clk);
    check(done == 1'b0, "R7 pulse", done, 0);
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < DEPTH; i++) mk[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);
    check(done == 1'b0, "R1 done", done, 0);
    host_check(0, "R1"); host_check(5, "R1"); host_check(63, "R1");

    // Directed cases
    do_req(32'h5000, 2'b00, 1, 0, 0, 0, "R4 load clean");
    host_check(5, "R6");
    do_req(32'h5004, 2'b01, 1, 0, 0, 0, "R5 store");
    host_check(5, "R5");
    do_req(32'h5ffc, 2'b00, 1, 0, 0, 0, "R4 load dirty");
    do_req(32'h9000, 2'b10, 1, 0, 0, 0, "R4 fetch");
    do_req(32'h9000, 2'b11, 1, 0, 0, 0, "R4 reserved");
    do_req(32'h7fff, 2'b01, 0, 0, 0, 0, "R3 offset");
    host_check(7, "R3");
    host_write(12, 7'b1011100);
    do_req(32'hC123, 2'b01, 1, 0, 0, 0, "R6 keep");
    host_check(12, "R6");
    do_req(32'h40000, 2'b00, 1, 0, 0, 0, "R2 at limit");
    host_check(0, "R2");
    mem_limit = 32'h10000;
    do_req(32'h15000, 2'b01, 1, 0, 0, 0, "R2 above limit");
    host_check(21, "R2");
    do_req(32'hFFFF, 2'b00, 1, 0, 0, 0, "R2 below limit");
    mem_limit = 32'h40000;
    do_req(32'h3000, 2'b00, 1, 2, 0, 0, "R8 stall");
    host_check(3, "R8");
    do_req(32'h4000, 2'b00, 1, 0, 1, 7'b0000001, "R9 reread");
    host_check(4, "R9");

    // Constrained random
    for (int it = 0; it < 250; it++) begin
      logic [31:0] lim, a;
      int hs;
      bit hw;
      lim = ((($urandom % 49) + 16) << 12);
      mem_limit = lim;
      a = $urandom % (lim + (lim >> 2));
      hs = ($urandom % 4 == 0) ? int'($urandom % 3) : 0;
      hw = ($urandom % 5 == 0);
      do_req(a, 2'($urandom % 4), 1'($urandom), hs, hw, 7'($urandom),
             "R3 R4 R5 R6 random");
      if (it % 8 == 0) host_write(int'($urandom % DEPTH), 7'($urandom));
      if (it % 5 == 0) host_check(int'(a[17:12]), "R8 readback");
    end
    for (int i = 0; i < DEPTH; i++) host_check(i, "R6 final");

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule